// File: doc/BRIEF.md
# Decimal Floating-Point Adder/Subtractor (Excess-3 Digits)

This block adds or subtracts two decimal floating-point numbers. Each value carries a fraction sign bit, a two-digit exponent stored with a bias of 50, and a fraction of `NDIG` decimal digits. Every digit, in both the exponent and the fraction, is held as its value plus three. A one-cycle `start` strobe captures both operands and the add/subtract select. A one-cycle `done` pulse then marks a normalized result in the same format, together with exponent overflow and underflow flags.

Internally the operand with the smaller exponent is shifted right one digit per cycle until the two exponents agree. Digits that fall off the end are dropped. When the effective signs differ, one fraction is turned into its ten's complement, and a single digit-serial-carry decimal adder forms the sum. A negative sum is recomplemented into a magnitude. The result is then normalized one digit per cycle. Precision is lost only by truncation.

Top module: `xs3_fp_addsub`

## Requirements
- R1: Operand and result layout, from the top bit down, is: bit 4·NDIG+8 is the fraction sign (1 = negative); bits 4·NDIG+7..4·NDIG+4 are the exponent tens digit; bits 4·NDIG+3..4·NDIG are the exponent units digit; then NDIG fraction digits with the most significant digit highest. Each digit is coded as value+3. The exponent field holds the true exponent plus 50, so −.371×10^−12 with NDIG=3 is sign 1, exponent 0110 1011, fraction 0110 1010 0100.
- R2: With `sub`=0 the result is a+b, and with `sub`=1 it is a−b. The fraction of the operand with the smaller exponent is first truncated by one digit per unit of exponent difference, and the digits shifted out are lost.
- R3: A nonzero result is normalized, meaning its leading fraction digit is not zero. A carry out of the top digit shifts the fraction right one digit, raises the exponent by one and drops the lowest digit. Leading zeros are removed by left shifts that lower the exponent.
- R4: A zero fraction sum yields the canonical zero: sign 0, exponent code 1000 0011 (true exponent 0), and every fraction digit coded 0011.
- R5: An operand whose fraction is all zero takes the other operand's exponent before alignment, so it never causes the other fraction to be truncated.
- R6: If the normalized exponent exceeds +49, `ovf` is 1. The exponent field then reads 1100 1100, and the sign and fraction digits are kept.
- R7: If the normalized exponent is below −50, `unf` is 1 and the result is the canonical zero. `ovf` and `unf` are never 1 together.
- R8: `done` is high for exactly one cycle, no more than 2·NDIG+5 cycles after the edge that captures `start`. `result`, `ovf` and `unf` change only in the cycle that `done` is high, and otherwise hold.
- R9: A `start` pulse that arrives while an operation is in progress is ignored.
- R10: After reset, `done`, `ovf` and `unf` are 0 and `result` is the canonical zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | One-cycle strobe that captures `opa`, `opb` and `sub` while idle |
| sub | input | 1 | 0 = add, 1 = subtract `opb` from `opa` |
| opa | input | 4·NDIG+9 | First operand |
| opb | input | 4·NDIG+9 | Second operand |
| result | output | 4·NDIG+9 | Normalized result, held until the next completion |
| done | output | 1 | One-cycle completion pulse |
| ovf | output | 1 | Exponent overflow of the last result |
| unf | output | 1 | Exponent underflow of the last result |

## Verification
Latency depends on the data. Alignment takes one cycle per digit of exponent difference, capped near NDIG+2 once the shifted fraction has emptied. Add and sign correction take two fixed cycles, and normalization takes up to NDIG cycles. The bench therefore does not assume a fixed delay. After each strobe it samples on the falling edge until `done` appears, and checks that the count stays within 2·NDIG+5. It compares result and flags on that same `done` cycle, and confirms that `done` has dropped one cycle later. Hold and ignored-strobe checks watch `result` and `done` for several cycles after completion, while inputs change and no accepted strobe is given.

// File: rtl/xs3fp_pkg.sv
package xs3fp_pkg;

  localparam int EXP_BIAS = 50;
  localparam int EXP_CODE_MAX = 99;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ALIGN,
    ST_ADD,
    ST_FIX,
    ST_NORM,
    ST_DONE
  } seq_state_t;

  function automatic logic [3:0] xs3_dec(input logic [3:0] c);
    return c - 4'd3;
  endfunction

  function automatic logic [3:0] xs3_enc(input logic [3:0] d);
    return d + 4'd3;
  endfunction

endpackage

// File: rtl/dec_digit_add.sv
module dec_digit_add (
  input  logic [3:0] a,
  input  logic [3:0] b,
  input  logic       ci,
  output logic [3:0] s,
  output logic       co
);
  logic [4:0] raw;

  always_comb begin
    raw = {1'b0, a} + {1'b0, b} + {4'd0, ci};
    co  = (raw > 5'd9);
    s   = raw[3:0] + (co ? 4'd6 : 4'd0);
  end
endmodule

// File: rtl/dec_ripple_add.sv
module dec_ripple_add #(
  parameter int ND = 9
) (
  input  logic [4*ND-1:0] x,
  input  logic [4*ND-1:0] y,
  input  logic            ci,
  output logic [4*ND-1:0] s,
  output logic            co
);
  logic [ND:0] cc;

  assign cc[0] = ci;

  for (genvar g = 0; g < ND; g++) begin : g_dig
    dec_digit_add u_dig (
      .a (x[4*g +: 4]),
      .b (y[4*g +: 4]),
      .ci(cc[g]),
      .s (s[4*g +: 4]),
      .co(cc[g+1])
    );
  end

  assign co = cc[ND];
endmodule

// File: rtl/xs3_fp_addsub.sv
module xs3_fp_addsub
  import xs3fp_pkg::*;
#(
  parameter int NDIG = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              sub,
  input  logic [4*NDIG+8:0] opa,
  input  logic [4*NDIG+8:0] opb,
  output logic [4*NDIG+8:0] result,
  output logic              done,
  output logic              ovf,
  output logic              unf
);
  localparam int FW = 4 * NDIG;   // fraction field width
  localparam int GW = FW + 4;     // fraction plus one guard digit
  localparam int W  = FW + 9;     // full operand width

  function automatic logic [FW-1:0] frac_dec(input logic [FW-1:0] c);
    logic [FW-1:0] r;
    for (int i = 0; i < NDIG; i++) r[4*i +: 4] = xs3_dec(c[4*i +: 4]);
    return r;
  endfunction

  function automatic logic [FW-1:0] frac_enc(input logic [FW-1:0] d);
    logic [FW-1:0] r;
    for (int i = 0; i < NDIG; i++) r[4*i +: 4] = xs3_enc(d[4*i +: 4]);
    return r;
  endfunction

  function automatic logic [GW-1:0] nines(input logic [GW-1:0] v);
    logic [GW-1:0] r;
    for (int i = 0; i <= NDIG; i++) r[4*i +: 4] = 4'd9 - v[4*i +: 4];
    return r;
  endfunction

  function automatic logic signed [8:0] exp_dec(input logic [7:0] c);
    logic [8:0] t, o;
    t = {5'd0, xs3_dec(c[7:4])};
    o = {5'd0, xs3_dec(c[3:0])};
    return $signed(t * 9'd10 + o);
  endfunction

  function automatic logic [7:0] exp_enc(input logic [6:0] e);
    logic [6:0] t, o;
    t = e / 7'd10;
    o = e % 7'd10;
    return {xs3_enc(t[3:0]), xs3_enc(o[3:0])};
  endfunction

  localparam logic [W-1:0] ZERO_CODE =
    {1'b0, exp_enc(7'(EXP_BIAS)), {NDIG{4'h3}}};

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rsync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  seq_state_t            state_q, state_d;
  logic [GW-1:0]         fa_q, fa_d, fb_q, fb_d, fr_q, fr_d;
  logic signed [8:0]     ea_q, ea_d, eb_q, eb_d, er_q, er_d;
  logic                  sa_q, sa_d, sb_q, sb_d, sr_q, sr_d;
  logic                  mixd_q, mixd_d, pos_q, pos_d;
  logic [W-1:0]          res_q, res_d;
  logic                  ovf_q, ovf_d, unf_q, unf_d;
  logic                  dp_en, out_en;

  logic [GW-1:0]         add_x, add_y, add_s;
  logic                  add_ci, add_co;
  logic [3:0]            guard_dig, lead_dig;

  assign guard_dig = fr_q[GW-1 -: 4];
  assign lead_dig  = fr_q[FW-1 -: 4];

  // shared decimal adder: signed-fraction sum, then recomplement
  always_comb begin
    add_x  = nines(fr_q);
    add_y  = '0;
    add_ci = 1'b1;
    if (state_q == ST_ADD) begin
      if (sa_q == sb_q) begin
        add_x  = fa_q;
        add_y  = fb_q;
        add_ci = 1'b0;
      end else begin
        add_x  = sa_q ? fb_q : fa_q;
        add_y  = nines(sa_q ? fa_q : fb_q);
        add_ci = 1'b1;
      end
    end
  end

  dec_ripple_add #(.ND(NDIG + 1)) u_add (
    .x (add_x),
    .y (add_y),
    .ci(add_ci),
    .s (add_s),
    .co(add_co)
  );

  // next-state and datapath
  always_comb begin
    state_d = state_q;
    fa_d = fa_q;  fb_d = fb_q;  fr_d = fr_q;
    ea_d = ea_q;  eb_d = eb_q;  er_d = er_q;
    sa_d = sa_q;  sb_d = sb_q;  sr_d = sr_q;
    mixd_d = mixd_q;  pos_d = pos_q;
    res_d = res_q;  ovf_d = ovf_q;  unf_d = unf_q;

    case (state_q)
      ST_IDLE: begin
        if (start) begin
          fa_d = {4'h0, frac_dec(opa[FW-1:0])};
          fb_d = {4'h0, frac_dec(opb[FW-1:0])};
          ea_d = exp_dec(opa[W-2:FW]);
          eb_d = exp_dec(opb[W-2:FW]);
          if (fa_d == '0)      ea_d = eb_d;
          else if (fb_d == '0) eb_d = ea_d;
          sa_d = opa[W-1];
          sb_d = opb[W-1] ^ sub;
          state_d = ST_ALIGN;
        end
      end
      ST_ALIGN: begin
        if (ea_q == eb_q) begin
          state_d = ST_ADD;
        end else if (ea_q < eb_q) begin
          if (fa_q == '0) ea_d = eb_q;
          else begin
            fa_d = fa_q >> 4;
            ea_d = ea_q + 9'sd1;
          end
        end else begin
          if (fb_q == '0) eb_d = ea_q;
          else begin
            fb_d = fb_q >> 4;
            eb_d = eb_q + 9'sd1;
          end
        end
      end
      ST_ADD: begin
        fr_d    = add_s;
        er_d    = ea_q;
        sr_d    = sa_q;
        mixd_d  = sa_q ^ sb_q;
        pos_d   = add_co;
        state_d = ST_FIX;
      end
      ST_FIX: begin
        if (mixd_q && !pos_q) begin
          fr_d = add_s;
          sr_d = 1'b1;
        end else if (mixd_q) begin
          sr_d = 1'b0;
        end
        state_d = ST_NORM;
      end
      ST_NORM: begin
        if (guard_dig != 4'd0) begin
          fr_d = fr_q >> 4;
          er_d = er_q + 9'sd1;
        end else if (fr_q == '0) begin
          res_d = ZERO_CODE;
          ovf_d = 1'b0;
          unf_d = 1'b0;
          state_d = ST_DONE;
        end else if (lead_dig == 4'd0) begin
          fr_d = fr_q << 4;
          er_d = er_q - 9'sd1;
        end else begin
          if (er_q < 9'sd0) begin
            res_d = ZERO_CODE;
            ovf_d = 1'b0;
            unf_d = 1'b1;
          end else if (er_q > 9'sd99) begin
            res_d = {sr_q, exp_enc(7'(EXP_CODE_MAX)), frac_enc(fr_q[FW-1:0])};
            ovf_d = 1'b1;
            unf_d = 1'b0;
          end else begin
            res_d = {sr_q, exp_enc(er_q[6:0]), frac_enc(fr_q[FW-1:0])};
            ovf_d = 1'b0;
            unf_d = 1'b0;
          end
          state_d = ST_DONE;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  assign dp_en  = (state_q != ST_IDLE) || start;
  assign out_en = (state_q == ST_NORM);

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= ST_IDLE;
      fa_q <= '0;  fb_q <= '0;  fr_q <= '0;
      ea_q <= '0;  eb_q <= '0;  er_q <= '0;
      sa_q <= 1'b0;  sb_q <= 1'b0;  sr_q <= 1'b0;
      mixd_q <= 1'b0;  pos_q <= 1'b0;
      res_q <= ZERO_CODE;
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (dp_en) begin
        fa_q <= fa_d;  fb_q <= fb_d;  fr_q <= fr_d;
        ea_q <= ea_d;  eb_q <= eb_d;  er_q <= er_d;
        sa_q <= sa_d;  sb_q <= sb_d;  sr_q <= sr_d;
        mixd_q <= mixd_d;  pos_q <= pos_d;
      end
      if (out_en) begin
        res_q <= res_d;
        ovf_q <= ovf_d;
        unf_q <= unf_d;
      end
    end
  end

  assign result = res_q;
  assign done   = (state_q == ST_DONE);
  assign ovf    = ovf_q;
  assign unf    = unf_q;

endmodule

// File: rtl/xs3_fp_addsub_chk.sv
module xs3_fp_addsub_chk #(
  parameter int NDIG = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [4*NDIG+8:0] result,
  input logic              done,
  input logic              ovf,
  input logic              unf
);
  localparam int FW = 4 * NDIG;
  localparam logic [4*NDIG+8:0] CANON_ZERO = {1'b0, 8'h83, {NDIG{4'h3}}};

  // R8: completion strobe lasts a single cycle
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: outputs move only together with the completion strobe
  assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> done);

  // R7: flags are mutually exclusive
  assert_flags_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(ovf && unf));

  // R7: underflow returns canonical zero
  assert_unf_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    unf |-> (result == CANON_ZERO));

  // R6: overflow clamps the exponent field to its top code
  assert_ovf_exp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> (result[FW+7:FW] == 8'hCC));

  // R3: a nonzero result has a nonzero leading digit
  assert_normalized_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && result != CANON_ZERO) |-> (result[FW-1 -: 4] != 4'h3));

  // R4: the zero code always carries a positive sign
  assert_zero_sign_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && result[FW-1:0] == {NDIG{4'h3}}) |-> (result == CANON_ZERO));

endmodule

bind xs3_fp_addsub xs3_fp_addsub_chk #(.NDIG(NDIG)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .start (start),
  .result(result),
  .done  (done),
  .ovf   (ovf),
  .unf   (unf)
);

// File: tb/sim_xs3_fp_addsub.sv
module sim_xs3_fp_addsub;
  localparam int CLK_PERIOD = 10;
  localparam int ND  = 3;
  localparam int FW  = 4 * ND;
  localparam int W   = FW + 9;
  localparam int TOP = 10 ** ND;
  localparam int LAT_MAX = 2 * ND + 5;
  localparam int WDOG = 190000;

  logic         clk;
  logic         rst_n;
  logic         start;
  logic         sub;
  logic [W-1:0] opa, opb;
  logic [W-1:0] result;
  logic         done, ovf, unf;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  xs3_fp_addsub #(.NDIG(ND)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .sub(sub),
    .opa(opa), .opb(opb), .result(result), .done(done), .ovf(ovf), .unf(unf)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [W-1:0] enc(input bit s, input int e, input int m);
    logic [W-1:0] r;
    int v;
    r[W-1] = s;
    r[FW+7:FW+4] = 4'((e / 10) + 3);
    r[FW+3:FW]   = 4'((e % 10) + 3);
    v = m;
    for (int i = 0; i < ND; i++) begin
      r[4*i +: 4] = 4'((v % 10) + 3);
      v = v / 10;
    end
    return r;
  endfunction

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > WDOG) begin
        n_chk++;
        n_bad++;
        $display("FAIL R8 watchdog: got %0d cycles expected at most %0d", cyc, WDOG);
        summary();
        $finish;
      end
    end
  end

  task automatic chk(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic ref_model(input bit s_a, input int e_a, input int m_a,
                           input bit s_b, input int e_b, input int m_b, input bit op_sub,
                           output logic [W-1:0] r, output bit ov, output bit un);
    int e, sv, mag;
    bit s;
    s_b = s_b ^ op_sub;
    if (m_a == 0)      e_a = e_b;
    else if (m_b == 0) e_b = e_a;
    while (e_a < e_b) begin m_a = m_a / 10; e_a++; end
    while (e_b < e_a) begin m_b = m_b / 10; e_b++; end
    e  = e_a;
    sv = (s_a ? -m_a : m_a) + (s_b ? -m_b : m_b);
    s  = (sv < 0);
    mag = s ? -sv : sv;
    ov = 1'b0;
    un = 1'b0;
    if (mag == 0) r = enc(1'b0, 50, 0);
    else begin
      if (mag >= TOP) begin mag = mag / 10; e++; end
      while (mag < TOP / 10) begin mag = mag * 10; e--; end
      if (e < 0) begin un = 1'b1; r = enc(1'b0, 50, 0); end
      else if (e > 99) begin ov = 1'b1; r = enc(s, 99, mag); end
      else r = enc(s, e, mag);
    end
  endtask

  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b, input bit op_sub,
                        output int lat);
    @(negedge clk);
    opa = a; opb = b; sub = op_sub; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic do_case(input bit s_a, input int e_a, input int m_a,
                         input bit s_b, input int e_b, input int m_b, input bit op_sub);
    logic [W-1:0] exp_r;
    bit exp_ov, exp_un;
    int lat;
    string tag;
    ref_model(s_a, e_a, m_a, s_b, e_b, m_b, op_sub, exp_r, exp_ov, exp_un);
    run_op(enc(s_a, e_a, m_a), enc(s_b, e_b, m_b), op_sub, lat);
    if (exp_ov)                          tag = "R6";
    else if (exp_un)                     tag = "R7";
    else if (exp_r == enc(1'b0, 50, 0))  tag = "R4";
    else if (m_a == 0 || m_b == 0)       tag = "R5";
    else                                 tag = "R2";
    n_chk++;
    if (lat > LAT_MAX) begin
      n_bad++;
      $display("FAIL R8 latency: got %0d expected at most %0d", lat, LAT_MAX);
    end
    chk(tag, result, exp_r);
    chk({tag, " flags"}, W'({ovf, unf}), W'({exp_ov, exp_un}));
    @(negedge clk);
    chk("R8 pulse", W'(done), W'(1'b0));
  endtask

  int m_set[7]  = '{0, 100, 101, 500, 555, 999, 909};
  int ea_set[3] = '{0, 50, 99};
  int eb_set[5] = '{0, 1, 50, 53, 99};

  initial begin
    int lat;
    logic [W-1:0] held;
    bit extra_done;
    rst_n = 1'b0; start = 1'b0; sub = 1'b0; opa = '0; opb = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R10: reset state
    chk("R10 result", result, enc(1'b0, 50, 0));
    chk("R10 done/flags", W'({done, ovf, unf}), '0);

    // R1: layout of -.371e-12 with a zero addend, both add and subtract
    run_op({1'b1, 8'b0110_1011, 12'b0110_1010_0100}, enc(1'b0, 50, 0), 1'b0, lat);
    chk("R1 add", result, {1'b1, 8'b0110_1011, 12'b0110_1010_0100});
    @(negedge clk);
    run_op(enc(1'b0, 50, 0), {1'b0, 8'b0110_1011, 12'b0110_1010_0100}, 1'b1, lat);
    chk("R1 sub", result, {1'b1, 8'b0110_1011, 12'b0110_1010_0100});
    @(negedge clk);

    // R3: carry out of the top digit, and leading-zero removal
    run_op(enc(1'b0, 50, 999), enc(1'b0, 50, 999), 1'b0, lat);
    chk("R3 carry", result, enc(1'b0, 51, 199));
    @(negedge clk);
    run_op(enc(1'b0, 50, 101), enc(1'b0, 50, 100), 1'b1, lat);
    chk("R3 shift left", result, enc(1'b0, 48, 100));
    @(negedge clk);

    // R5: zero operand with a large exponent leaves the other intact
    run_op(enc(1'b0, 99, 0), enc(1'b1, 45, 123), 1'b0, lat);
    chk("R5 zero operand", result, enc(1'b1, 45, 123));

    // R8: result holds while inputs move without a strobe
    held = result;
    opa = enc(1'b1, 70, 777); opb = enc(1'b0, 10, 321);
    repeat (5) @(negedge clk);
    chk("R8 hold", result, held);

    // R9: strobe while busy is ignored
    @(negedge clk);
    opa = enc(1'b0, 50, 500); opb = enc(1'b0, 50, 100); sub = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    opa = enc(1'b0, 99, 999); opb = enc(1'b0, 99, 999); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 40) begin @(negedge clk); lat++; end
    chk("R9 first result kept", result, enc(1'b0, 50, 600));
    chk("R9 flags", W'({ovf, unf}), '0);
    extra_done = 1'b0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (done) extra_done = 1'b1;
    end
    chk("R9 no second completion", W'(extra_done), '0);

    // sweep: mantissas x exponents x signs x operation
    foreach (ea_set[ia])
      foreach (eb_set[ib])
        foreach (m_set[ma])
          foreach (m_set[mb])
            for (int sg = 0; sg < 8; sg++)
              do_case(sg[0], ea_set[ia], m_set[ma], sg[1], eb_set[ib], m_set[mb], sg[2]);

    summary();
    $finish;
  end
endmodule